// File: doc/BRIEF.md
# Fetch Thread Selector

This block decides, every cycle, which hardware thread of a multithreaded core is allowed to use the instruction fetch path. It does not fetch anything itself. It looks at each thread's current state, at the mask of threads that are active, and at two occupancy figures each thread reports: its entries in the instruction queue and its entries in the load/store queue. A two-bit policy input selects the rule. The result is a thread number with a valid flag.

There are four policies. The first always picks thread 0. The second rotates through an ordered priority list. The other two pick the least loaded thread, judged by one of the two occupancy figures. The grant is purely combinational. The only stored state is the priority list, which changes on a clock edge when the fetch side accepts a round-robin grant. A drain request holds back every grant.

A build with a single hardware thread uses a reduced path. It grants that thread whenever the thread is active and eligible.

Top module: `fetch_thread_sel`

## Requirements
- R1: Status codes are 3 bits per thread, with thread i in bits [3i+2:3i]. The codes are: 0 idle, 1 running, 2 squashing, 3 blocked, 4 waiting for a cache response, 5 waiting for a cache retry, 6 cache fill complete. Outside the thread-0 policy, a thread may be granted only if its active bit is 1 and its code is 0, 1 or 6.
- R2: While `drain_i` is 1, `gnt_valid_o` is 0 and `gnt_tid_o` is 0, whatever the policy.
- R3: In policy codes 1, 2 and 3, `gnt_valid_o` is 0 when no thread is eligible.
- R4: Policy code 0 grants thread 0 whenever no drain is pending, regardless of status and active bits.
- R5: Policy code 1 scans the priority list from its head and grants the first eligible thread.
- R6: When `take_i` is 1 while a policy-1 grant is valid, the next clock edge removes the granted thread from its position and appends it at the tail. The threads behind it each move up one place. With `take_i` at 0, the list is unchanged.
- R7: After reset the list holds the threads in ascending order. So with all threads eligible and every grant taken, the grants come out as 0, 1, 2, 3.
- R8: Policy code 2 grants the eligible thread with the smallest instruction-queue count. On a tie, the lower thread number wins.
- R9: Policy code 3 applies the same rule to the load/store-queue counts, and the instruction-queue counts then have no effect on the grant.
- R10: The priority list always holds every thread number exactly once.
- R11: With one hardware thread, a grant is made only when that thread is active and eligible. Policy 0 is the exception and always grants it. Drain blocks all grants.
- R12: Grants taken under policies 0, 2 or 3 leave the priority list unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 3*NTHR | Per-thread status codes |
| active_i | input | NTHR | Active-thread mask |
| iq_cnt_i | input | CNT_W*NTHR | Per-thread instruction-queue occupancy |
| lsq_cnt_i | input | CNT_W*NTHR | Per-thread load/store-queue occupancy |
| policy_i | input | 2 | 0 thread-0, 1 round-robin, 2 IQ count, 3 LSQ count |
| drain_i | input | 1 | Drain pending; suppresses grants |
| take_i | input | 1 | The current grant is consumed this cycle |
| gnt_valid_o | output | 1 | A thread is granted |
| gnt_tid_o | output | TID_W | Granted thread number |

## Verification
The assertions check the following on every cycle:
- drain suppression;
- eligibility of any granted thread;
- the empty-grant case;
- the thread-0 policy;
- the list staying a permutation;
- the list holding still when nothing is consumed;
- the granted thread landing at the tail.

Only the bench's scenarios can show that the round-robin choice is the first eligible entry in list order and that occupancy choices take the minimum with the tie rule. The bench reaches these by tracking its own copy of the list over long random runs, which also shows that the list ignores grants made under the other policies.

// File: rtl/ftsel_pkg.sv
package ftsel_pkg;

  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    TS_IDLE       = 3'd0,
    TS_RUN        = 3'd1,
    TS_SQUASH     = 3'd2,
    TS_BLOCK      = 3'd3,
    TS_WAIT_RSP   = 3'd4,
    TS_WAIT_RETRY = 3'd5,
    TS_FILL_DONE  = 3'd6
  } thr_state_e;

  typedef enum logic [1:0] {
    SEL_SOLO = 2'd0,
    SEL_RR   = 2'd1,
    SEL_IQ   = 2'd2,
    SEL_LSQ  = 2'd3
  } sel_policy_e;

  // A thread can take the fetch slot only in these three states.
  function automatic logic state_can_fetch(logic [ST_W-1:0] s);
    return (s == TS_IDLE) || (s == TS_RUN) || (s == TS_FILL_DONE);
  endfunction

endpackage

// File: rtl/ftsel_elig.sv
module ftsel_elig
  import ftsel_pkg::*;
#(
  parameter int NTHR = 4
) (
  input  logic [NTHR*ST_W-1:0] status_i,
  input  logic [NTHR-1:0]      active_i,
  output logic [NTHR-1:0]      elig_o
);

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    logic [ST_W-1:0] st;
    assign st        = status_i[g*ST_W +: ST_W];
    assign elig_o[g] = active_i[g] && state_can_fetch(st);
  end

endmodule

// File: rtl/ftsel_occ.sv
module ftsel_occ #(
  parameter int NTHR  = 4,
  parameter int CNT_W = 6,
  parameter int TID_W = 2
) (
  input  logic [NTHR-1:0]       elig_i,
  input  logic [NTHR*CNT_W-1:0] cnt_i,
  output logic                  hit_o,
  output logic [TID_W-1:0]      tid_o
);

  logic [CNT_W-1:0] best_c;
  logic [CNT_W-1:0] cur_c;

  // Linear scan from thread 0 upward; strict less-than keeps the lower
  // thread on a tie.
  always_comb begin
    hit_o  = 1'b0;
    tid_o  = '0;
    best_c = '1;
    cur_c  = '0;
    for (int i = 0; i < NTHR; i++) begin
      cur_c = cnt_i[i*CNT_W +: CNT_W];
      if (elig_i[i] && (!hit_o || (cur_c < best_c))) begin
        hit_o  = 1'b1;
        best_c = cur_c;
        tid_o  = TID_W'(i);
      end
    end
  end

endmodule

// File: rtl/ftsel_rr.sv
module ftsel_rr #(
  parameter int NTHR  = 4,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTHR-1:0]  elig_i,
  input  logic             take_en_i,
  output logic             hit_o,
  output logic [TID_W-1:0] tid_o
);

  localparam int POS_W = TID_W;

  logic [NTHR-1:0][TID_W-1:0] list_q;
  logic [NTHR-1:0][TID_W-1:0] list_d;
  logic [POS_W-1:0]           hit_pos;
  logic [NTHR-1:0]            present;

  // Head-first scan of the priority list.
  always_comb begin
    hit_o   = 1'b0;
    hit_pos = '0;
    tid_o   = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (!hit_o && elig_i[list_q[i]]) begin
        hit_o   = 1'b1;
        hit_pos = POS_W'(i);
        tid_o   = list_q[i];
      end
    end
  end

  // Remove the granted entry, close the gap, append it at the tail.
  always_comb begin
    list_d = list_q;
    if (take_en_i) begin
      for (int i = 0; i < NTHR - 1; i++) begin
        if (POS_W'(i) >= hit_pos) list_d[i] = list_q[i+1];
      end
      list_d[NTHR-1] = list_q[hit_pos];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHR; i++) list_q[i] <= TID_W'(i);
    end else if (take_en_i) begin
      list_q <= list_d;
    end
  end

  always_comb begin
    present = '0;
    for (int i = 0; i < NTHR; i++) present[list_q[i]] = 1'b1;
  end

  // R10: the list remains a permutation of all thread numbers
  a_r10_list_perm: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(present) == NTHR);

  // R6: without a consumed grant the list holds
  a_r6_list_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take_en_i |=> $stable(list_q));

  // R6: a consumed grant ends up at the tail
  a_r6_to_tail: assert property (@(posedge clk) disable iff (!rst_n)
    take_en_i |=> list_q[NTHR-1] == $past(tid_o));

endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
  import ftsel_pkg::*;
#(
  parameter  int NTHR  = 4,
  parameter  int CNT_W = 6,
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NTHR*ST_W-1:0]  status_i,
  input  logic [NTHR-1:0]       active_i,
  input  logic [NTHR*CNT_W-1:0] iq_cnt_i,
  input  logic [NTHR*CNT_W-1:0] lsq_cnt_i,
  input  logic [1:0]            policy_i,
  input  logic                  drain_i,
  input  logic                  take_i,
  output logic                  gnt_valid_o,
  output logic [TID_W-1:0]      gnt_tid_o
);

  sel_policy_e     pol;
  logic [NTHR-1:0] elig;

  assign pol = sel_policy_e'(policy_i);

  ftsel_elig #(.NTHR(NTHR)) u_elig (
    .status_i (status_i),
    .active_i (active_i),
    .elig_o   (elig)
  );

  if (NTHR == 1) begin : g_one
    always_comb begin
      gnt_tid_o   = '0;
      gnt_valid_o = !drain_i && ((pol == SEL_SOLO) || elig[0]);
    end
  end else begin : g_multi
    logic                   rr_hit, occ_hit, rr_take;
    logic [TID_W-1:0]       rr_tid, occ_tid;
    logic [NTHR*CNT_W-1:0]  occ_cnt;

    assign occ_cnt = (pol == SEL_LSQ) ? lsq_cnt_i : iq_cnt_i;
    assign rr_take = take_i && gnt_valid_o && (pol == SEL_RR);

    ftsel_rr #(.NTHR(NTHR), .TID_W(TID_W)) u_rr (
      .clk       (clk),
      .rst_n     (rst_n),
      .elig_i    (elig),
      .take_en_i (rr_take),
      .hit_o     (rr_hit),
      .tid_o     (rr_tid)
    );

    ftsel_occ #(.NTHR(NTHR), .CNT_W(CNT_W), .TID_W(TID_W)) u_occ (
      .elig_i (elig),
      .cnt_i  (occ_cnt),
      .hit_o  (occ_hit),
      .tid_o  (occ_tid)
    );

    always_comb begin
      unique case (pol)
        SEL_SOLO: begin gnt_valid_o = 1'b1;    gnt_tid_o = '0;      end
        SEL_RR:   begin gnt_valid_o = rr_hit;  gnt_tid_o = rr_tid;  end
        default:  begin gnt_valid_o = occ_hit; gnt_tid_o = occ_tid; end
      endcase
      if (drain_i) begin
        gnt_valid_o = 1'b0;
        gnt_tid_o   = '0;
      end
    end
  end

  // R2: drain suppresses every grant
  a_r2_drain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    drain_i |-> !gnt_valid_o);

  // R1: outside the thread-0 policy only eligible threads are granted
  a_r1_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && pol != SEL_SOLO) |-> elig[gnt_tid_o]);

  // R3: nothing eligible means no grant
  a_r3_none_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (pol != SEL_SOLO && elig == '0) |-> !gnt_valid_o);

  // R4: thread-0 policy grants thread 0 unless draining
  a_r4_solo_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == SEL_SOLO && !drain_i) |-> (gnt_valid_o && gnt_tid_o == '0));

endmodule

// File: tb/fetch_thread_sel_test.sv
module fetch_thread_sel_test;

  localparam int NT = 4;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT*3-1:0]  status_v;
  logic [NT-1:0]    active_v;
  logic [NT*CW-1:0] iq_v, lsq_v;
  logic [1:0]       policy;
  logic             drain, take;
  logic             gv;
  logic [1:0]       gt;

  logic [2:0]    status1;
  logic          active1;
  logic          gv1;
  logic [0:0]    gt1;

  int st[NT];
  int iqc[NT];
  int lsqc[NT];
  int rr_list[NT];
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  fetch_thread_sel #(.NTHR(NT), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .status_i(status_v), .active_i(active_v),
    .iq_cnt_i(iq_v), .lsq_cnt_i(lsq_v), .policy_i(policy), .drain_i(drain),
    .take_i(take), .gnt_valid_o(gv), .gnt_tid_o(gt)
  );

  fetch_thread_sel #(.NTHR(1), .CNT_W(CW)) uut_one (
    .clk(clk), .rst_n(rst_n), .status_i(status1), .active_i(active1),
    .iq_cnt_i(iq_v[CW-1:0]), .lsq_cnt_i(lsq_v[CW-1:0]), .policy_i(policy),
    .drain_i(drain), .take_i(take), .gnt_valid_o(gv1), .gnt_tid_o(gt1)
  );

  function automatic bit can_go(int s, bit a);
    return a && (s == 0 || s == 1 || s == 6);
  endfunction

  function automatic void model(output bit v, output int t);
    int best;
    v = 0; t = 0; best = 0;
    if (drain) return;
    if (policy == 2'd0) begin v = 1; return; end
    if (policy == 2'd1) begin
      for (int i = 0; i < NT; i++)
        if (!v && can_go(st[rr_list[i]], active_v[rr_list[i]])) begin
          v = 1; t = rr_list[i];
        end
      return;
    end
    for (int i = 0; i < NT; i++) begin
      int c;
      c = (policy == 2'd3) ? lsqc[i] : iqc[i];
      if (can_go(st[i], active_v[i]) && (!v || c < best)) begin
        v = 1; t = i; best = c;
      end
    end
  endfunction

  function automatic string auto_tag(bit v);
    if (drain) return "R2";
    if (policy == 2'd0) return "R4";
    if (!v) return "R3";
    if (policy == 2'd1) return "R5 R1";
    if (policy == 2'd2) return "R8 R1";
    return "R9 R1";
  endfunction

  task automatic apply();
    for (int i = 0; i < NT; i++) begin
      status_v[i*3 +: 3] = 3'(st[i]);
      iq_v[i*CW +: CW]   = CW'(iqc[i]);
      lsq_v[i*CW +: CW]  = CW'(lsqc[i]);
    end
  endtask

  task automatic step(string tag);
    bit ev, ev1;
    int et;
    apply();
    #1;
    model(ev, et);
    checks++;
    if (gv !== ev || (ev && gt !== 2'(et))) begin
      fails++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
               (tag == "") ? auto_tag(ev) : tag, gv, gt, ev, et);
    end
    ev1 = !drain && (policy == 2'd0 || can_go(int'(status1), active1));
    checks++;
    if (gv1 !== ev1 || gt1 !== 1'b0) begin
      fails++;
      $display("FAIL R11: got valid=%0b tid=%0d, expected valid=%0b tid=0",
               gv1, gt1, ev1);
    end
    @(posedge clk);
    if (take && ev && policy == 2'd1 && rst_n) begin
      int p, g;
      p = 0;
      for (int i = 0; i < NT; i++) if (rr_list[i] == et) p = i;
      g = rr_list[p];
      for (int i = p; i < NT - 1; i++) rr_list[i] = rr_list[i+1];
      rr_list[NT-1] = g;
    end
    @(negedge clk);
  endtask

  task automatic all_run();
    for (int i = 0; i < NT; i++) begin st[i] = 1; iqc[i] = 0; lsqc[i] = 0; end
    active_v = '1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < NT; i++) rr_list[i] = i;
    all_run();
    status1 = 3'd1; active1 = 1'b1;
    policy = 2'd1; drain = 0; take = 0;
    apply();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: reset order, every grant taken
    take = 1;
    for (int k = 0; k < NT; k++) step("R7");
    // R6: not consumed, the same thread stays granted
    take = 0;
    step("R6"); step("R6");
    // R5: head skips a blocked thread
    st[0] = 3; take = 1;
    step("R5"); step("R5");
    st[0] = 1;
    // R12: taken grants under other policies leave the list alone
    policy = 2'd2; iqc[2] = 5; step("R12 R8");
    policy = 2'd0; step("R12 R4");
    policy = 2'd1; step("R12"); step("R10"); step("R10"); step("R10");
    // R8: tie goes to lower thread
    policy = 2'd2; all_run(); iqc[0] = 4; iqc[1] = 2; iqc[3] = 2;
    step("R8");
    // R9: LSQ counts rule, IQ counts ignored
    policy = 2'd3; lsqc[0] = 1; lsqc[1] = 3; lsqc[2] = 0; lsqc[3] = 0;
    iqc[2] = 0; iqc[3] = 9; step("R9");
    iqc[2] = 40; iqc[3] = 0; step("R9");
    // R3: nothing eligible
    for (int i = 0; i < NT; i++) st[i] = 4;
    policy = 2'd1; step("R3"); policy = 2'd2; step("R3");
    // R4: thread-0 policy with nothing eligible
    policy = 2'd0; active_v = '0; step("R4");
    // R2: drain
    all_run(); drain = 1; policy = 2'd1; step("R2"); policy = 2'd0; step("R2");
    drain = 0;
    // R11: single-thread build, inactive or ineligible
    policy = 2'd1; active1 = 0; step("R11");
    active1 = 1; status1 = 3'd2; step("R11");
    status1 = 3'd6; step("R11");
    // R1: idle and fill-complete are eligible, others are not
    policy = 2'd1; st[0] = 5; st[1] = 0; st[2] = 6; st[3] = 2; step("R1");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < NT; i++) begin
        st[i]   = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 6) : 1;
        iqc[i]  = $urandom_range(0, 3);
        lsqc[i] = $urandom_range(0, 3);
        active_v[i] = ($urandom_range(0, 5) != 0);
      end
      status1 = 3'($urandom_range(0, 6));
      active1 = ($urandom_range(0, 3) != 0);
      policy  = 2'($urandom_range(0, 3));
      drain   = ($urandom_range(0, 15) == 0);
      take    = ($urandom_range(0, 3) != 0);
      step("");
    end
    summary();
  end

endmodule